// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Byte-Wise Bypass

This block is a synchronous single-port memory whose write data trails its address by one clock. A write command (address, select, global write enable, per-lane enables) is sampled on one rising edge. Its data word is sampled on the next rising edge. The completed write is not put into the array at once. It waits in a holding buffer and goes into the array on the edge that brings in the data of the next write. Because of this, a read that follows a write needs no bus turnaround cycle.

Every read compares its address with the buffered write. On a match, the bytes that write enabled come from the buffer and the other bytes come from the array. To the user the memory therefore looks as if every write took effect at once. Read data is loaded into an output register on the falling edge after the read was sampled.

The block drives a pad-enable flag that is true only after a read cycle, and only when the asynchronous output enable is high and the memory is awake. A synchronous sleep input parks the block. The stored contents survive sleep, and the block ignores commands for a fixed number of recovery edges after sleep is released.

Top module: `latewrite_sram`

## Requirements
- R1: A write command is sampled on a rising edge where `sel`=1 and `wrEn`=1. The data word for that write is the value on `dataIn` at the next rising edge, whatever command is presented on that edge.
- R2: A read (`sel`=1, `wrEn`=0) returns, in every byte lane, the most recently written value for that address. This holds even when that write has not yet been committed to the array, including a read placed directly after the write.
- R3: Lane l covers bits [l*LANE_W+LANE_W-1 : l*LANE_W] and is written only when `byteWrEn[l]`=1. After a partial write, a read returns the new lanes together with the old contents of the other lanes.
- R4: Consecutive writes, to the same address or to different addresses, all take effect in issue order. No write is lost.
- R5: A cycle with `sel`=0 neither reads nor writes. After the falling edge that follows such a cycle, and after a write cycle, `dataDrive` is 0.
- R6: Read data and `dataDrive`=1 appear at the falling edge after the rising edge that sampled the read. They hold until the next falling edge.
- R7: When `outEn`=0, `dataDrive` is 0 at once, without waiting for a clock edge. When `outEn` rises again, `dataDrive` returns without a clock edge.
- R8: From a rising edge that samples `sleep`=1, commands are ignored and `dataDrive` is 0. A write that was sampled before sleep still completes, and the memory contents are kept.
- R9: After `sleep` is sampled low, the first RECOVER_CYCLES rising edges ignore commands. The next edge accepts them.
- R10: After reset, `dataDrive` is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on rising edge, output register loaded on falling edge |
| rstN | input | 1 | Active-low asynchronous reset of control and holding state |
| addr | input | ADDR_W | Word address of the command |
| sel | input | 1 | Synchronous select, 1 = active cycle |
| wrEn | input | 1 | Global write enable, 1 = write, 0 = read |
| byteWrEn | input | LANES | Per-lane write enables, active high, sampled with the command |
| dataIn | input | LANES*LANE_W | Write data, sampled one edge after its command |
| outEn | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Synchronous sleep request, active high |
| dataOut | output | LANES*LANE_W | Output register contents |
| dataDrive | output | 1 | Pad enable; 0 means the data pins float |

## Verification
The bench builds the block with ADDR_W=4, four 9-bit lanes and RECOVER_CYCLES=3. This keeps the whole 16-word array small enough to sweep in full: each address is written and then read both straight from the buffer and from the array, and all fifteen non-empty lane-enable masks are tried against one address. The short recovery count puts the exact edge where commands start being accepted again within reach of a direct check.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

  // Strobes from the control unit to the datapath, one per rising edge.
  typedef struct packed {
    logic capCmd;    // latch address of an accepted command
    logic capWrite;  // accepted command is a write: latch lane enables
    logic takeData;  // dataIn belongs to the write of the previous edge
    logic launchRd;  // previous edge accepted a read: load output at falling edge
  } strobe_t;

endpackage

// File: rtl/lwsram_ctrl.sv
module lwsram_ctrl
  import lwsram_pkg::*;
#(
  parameter int RECOVER_CYCLES = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sel,
  input  logic    wrEn,
  input  logic    sleep,
  output strobe_t strb,
  output logic    quiet
);

  localparam int CW = $clog2(RECOVER_CYCLES + 2);

  logic [CW-1:0] recoverCnt;
  logic          sleepQ;
  logic          wrPendQ;
  logic          rdPendQ;
  logic          ready;
  logic          acceptWr;
  logic          acceptRd;

  assign ready    = !sleep && (recoverCnt == '0);
  assign acceptWr = sel && wrEn && ready;
  assign acceptRd = sel && !wrEn && ready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recoverCnt <= '0;
      sleepQ     <= 1'b0;
      wrPendQ    <= 1'b0;
      rdPendQ    <= 1'b0;
    end else begin
      sleepQ  <= sleep;
      wrPendQ <= acceptWr;
      rdPendQ <= acceptRd;
      if (sleep)
        recoverCnt <= CW'(RECOVER_CYCLES);
      else if (recoverCnt != '0)
        recoverCnt <= recoverCnt - 1'b1;
    end
  end

  always_comb begin
    strb.capCmd   = acceptWr || acceptRd;
    strb.capWrite = acceptWr;
    strb.takeData = wrPendQ;
    strb.launchRd = rdPendQ;
  end

  assign quiet = sleepQ || (recoverCnt != '0);

endmodule

// File: rtl/lwsram_datapath.sv
module lwsram_datapath
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES-1:0]         byteWrEn,
  input  logic [LANES*LANE_W-1:0]  dataIn,
  output logic [LANES*LANE_W-1:0]  doutQ,
  output logic                     driveQ
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0] capAddr;
  logic [LANES-1:0]  capBe;
  logic [ADDR_W-1:0] bufAddr;
  logic [LANES-1:0]  bufBe;
  logic [DATA_W-1:0] bufData;
  logic              bufValid;

  logic [DATA_W-1:0] arrWord;
  logic [DATA_W-1:0] mergedWord;
  logic              addrHit;

  // Command capture and holding buffer.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr  <= '0;
      capBe    <= '0;
      bufAddr  <= '0;
      bufBe    <= '0;
      bufData  <= '0;
      bufValid <= 1'b0;
    end else begin
      if (strb.capCmd)   capAddr <= addr;
      if (strb.capWrite) capBe   <= byteWrEn;
      if (strb.takeData) begin
        bufAddr  <= capAddr;
        bufBe    <= capBe;
        bufData  <= dataIn;
        bufValid <= 1'b1;
      end
    end
  end

  // The buffered write is retired when the next write's data arrives.
  always_ff @(posedge clk) begin
    if (strb.takeData && bufValid) begin
      for (int l = 0; l < LANES; l++) begin
        if (bufBe[l])
          mem[bufAddr][l*LANE_W +: LANE_W] <= bufData[l*LANE_W +: LANE_W];
      end
    end
  end

  assign arrWord = mem[capAddr];
  assign addrHit = bufValid && (bufAddr == capAddr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mergedWord[g*LANE_W +: LANE_W] =
      (addrHit && bufBe[g]) ? bufData[g*LANE_W +: LANE_W]
                            : arrWord[g*LANE_W +: LANE_W];
  end

  // Falling-edge output register.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      doutQ  <= '0;
      driveQ <= 1'b0;
    end else begin
      driveQ <= strb.launchRd;
      if (strb.launchRd) doutQ <= mergedWord;
    end
  end

endmodule

// File: rtl/latewrite_sram.sv
module latewrite_sram
  import lwsram_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter int LANES          = 4,
  parameter int LANE_W         = 9,
  parameter int RECOVER_CYCLES = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     sel,
  input  logic                     wrEn,
  input  logic [LANES-1:0]         byteWrEn,
  input  logic [LANES*LANE_W-1:0]  dataIn,
  input  logic                     outEn,
  input  logic                     sleep,
  output logic [LANES*LANE_W-1:0]  dataOut,
  output logic                     dataDrive
);

  localparam int DATA_W = LANES * LANE_W;

  strobe_t           strb;
  logic              quiet;
  logic              driveQ;
  logic [DATA_W-1:0] doutQ;

  lwsram_ctrl #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sel   (sel),
    .wrEn  (wrEn),
    .sleep (sleep),
    .strb  (strb),
    .quiet (quiet)
  );

  lwsram_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .addr     (addr),
    .byteWrEn (byteWrEn),
    .dataIn   (dataIn),
    .doutQ    (doutQ),
    .driveQ   (driveQ)
  );

  assign dataOut   = doutQ;
  assign dataDrive = outEn && driveQ && !quiet;

endmodule

// File: rtl/latewrite_sram_checker.sv
module latewrite_sram_checker (
  input logic clk,
  input logic rstN,
  input logic sel,
  input logic wrEn,
  input logic sleep,
  input logic outEn,
  input logic dataDrive,
  input logic rdAccept
);

  logic started;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) started <= 1'b0;
    else       started <= 1'b1;
  end

  p_oe_float_r7: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> !dataDrive);

  p_sleep_float_r8: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(sleep)) |-> !dataDrive);

  p_idle_float_r5: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(!(sel && !wrEn))) |-> !dataDrive);

  p_read_drive_r6: assert property (@(posedge clk) disable iff (!rstN)
    (started && $past(rdAccept) && outEn) |-> dataDrive);

endmodule

bind latewrite_sram latewrite_sram_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sel       (sel),
  .wrEn      (wrEn),
  .sleep     (sleep),
  .outEn     (outEn),
  .dataDrive (dataDrive),
  .rdAccept  (strb.capCmd && !strb.capWrite)
);

// File: tb/latewrite_sram_test.sv
module latewrite_sram_test;

  localparam int AW    = 4;
  localparam int NL    = 4;
  localparam int LW    = 9;
  localparam int DW    = NL * LW;
  localparam int REC   = 3;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          sel = 1'b0;
  logic          wrEn = 1'b0;
  logic [NL-1:0] byteWrEn = '0;
  logic [DW-1:0] dataIn = '0;
  logic          outEn = 1'b1;
  logic          sleep = 1'b0;
  logic [DW-1:0] dataOut;
  logic          dataDrive;

  logic [DW-1:0] model [WORDS];
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  latewrite_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .RECOVER_CYCLES(REC)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .sel(sel), .wrEn(wrEn),
    .byteWrEn(byteWrEn), .dataIn(dataIn), .outEn(outEn), .sleep(sleep),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );

  function automatic logic [DW-1:0] pat(int a, int s);
    return DW'(a + 1) * 36'h0_9E37_79B9 + DW'(s) * 36'h3_1415_9265;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(int a, logic [NL-1:0] be, logic [DW-1:0] d);
    addr = AW'(a); sel = 1'b1; wrEn = 1'b1; byteWrEn = be;
    @(posedge clk); #1;
    sel = 1'b0; wrEn = 1'b0;
    dataIn = d;
    for (int l = 0; l < NL; l++)
      if (be[l]) model[a][l*LW +: LW] = d[l*LW +: LW];
  endtask

  task automatic doRead(int a, string tag);
    addr = AW'(a); sel = 1'b1; wrEn = 1'b0;
    @(posedge clk); #1;
    sel = 1'b0;
    @(negedge clk); #2;
    chk({tag, " drive"}, DW'(dataDrive), DW'(1));
    chk(tag, dataOut, model[a]);
  endtask

  task automatic idle(int n);
    sel = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 drive in reset", DW'(dataDrive), DW'(0));
    rstN = 1'b1;
    idle(2);
    chk("R10 drive after reset", DW'(dataDrive), DW'(0));

    // R1 R2: fill every word, read back (last one still buffered)
    for (int a = 0; a < WORDS; a++) doWrite(a, '1, pat(a, 1));
    for (int a = 0; a < WORDS; a++) doRead(a, "R1 fill readback");

    // R2: read directly after write, every address
    for (int a = 0; a < WORDS; a++) begin
      doWrite(a, '1, pat(a, 2));
      doRead(a, "R2 bypass read");
    end

    // R3: all lane masks, via buffer and via array
    for (int m = 1; m < (1 << NL); m++) begin
      doWrite(5, NL'(m), pat(m, 3));
      doRead(5, "R3 partial from buffer");
      doWrite(6, NL'(15 - m), pat(m, 4));
      doRead(5, "R3 partial from array");
      doRead(6, "R3 partial other word");
    end

    // R4: back-to-back writes, same and different addresses
    doWrite(9, 4'b0011, pat(9, 5));
    doWrite(9, 4'b1100, pat(9, 6));
    doWrite(9, 4'b0001, pat(9, 7));
    doWrite(10, '1, pat(10, 5));
    doWrite(11, '1, pat(11, 5));
    doWrite(12, 4'b0110, pat(12, 5));
    for (int a = 9; a <= 12; a++) doRead(a, "R4 burst order");

    // R5: deselected write is ignored
    addr = 4'd2; sel = 1'b0; wrEn = 1'b1; byteWrEn = '1;
    @(posedge clk); #1;
    dataIn = ~pat(2, 9);
    idle(1);
    wrEn = 1'b0;
    doRead(2, "R5 deselect no write");

    // R6 hold until the next falling edge, then R5 float
    sel = 1'b0;
    @(posedge clk); #2;
    chk("R6 hold drive", DW'(dataDrive), DW'(1));
    chk("R6 hold data", dataOut, model[2]);
    @(negedge clk); #2;
    chk("R5 float after idle", DW'(dataDrive), DW'(0));
    doWrite(3, '1, pat(3, 9));
    @(negedge clk); #2;
    chk("R5 float after write", DW'(dataDrive), DW'(0));
    idle(1);

    // R7: asynchronous output enable
    outEn = 1'b0;
    addr = 4'd3; sel = 1'b1; wrEn = 1'b0;
    @(posedge clk); #1;
    sel = 1'b0;
    @(negedge clk); #2;
    chk("R7 oe low floats", DW'(dataDrive), DW'(0));
    outEn = 1'b1; #1;
    chk("R7 oe high drives", DW'(dataDrive), DW'(1));
    chk("R7 data", dataOut, model[3]);
    idle(1);

    // R8 R9: sleep with a write in flight, then recovery
    doWrite(8, '1, pat(8, 10));
    sleep = 1'b1;
    addr = 4'd7; sel = 1'b1; wrEn = 1'b1; byteWrEn = '1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      dataIn = ~pat(7, k);
      chk("R8 asleep floats", DW'(dataDrive), DW'(0));
    end
    sleep = 1'b0;
    for (int k = 0; k < REC; k++) begin
      @(posedge clk); #1;
      chk("R9 recovering floats", DW'(dataDrive), DW'(0));
    end
    sel = 1'b0; wrEn = 1'b0;
    doRead(7, "R9 recovery ignored writes");
    doRead(8, "R8 write before sleep kept");
    doWrite(7, '1, pat(7, 11));
    doRead(7, "R9 awake write accepted");
    doRead(4, "R8 contents kept");

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule